// File: doc/BRIEF.md
# Four-Channel DMA Priority Arbiter

This block chooses which of four DMA channels may use the shared transfer engine. Each channel raises a request line. While no grant is outstanding, the arbiter picks one requester and drives a one-hot grant vector. That grant stays put until the engine pulses the completion strobe for the transfer unit. Only then does the arbiter consider the requests again.

A two-bit mode input selects the priority order. Three of the orders are fixed, and two of those are deliberately not ascending. The fourth order rotates: the channel served most recently falls to the bottom.

A master enable must be high for any grant to appear. Two sticky fault flags stop all transfers while either is set: one for an address fault and one for a non-maskable interrupt. They are raised by pulse inputs and lowered only by an explicit clear input. The grant and the completion strobe act as a valid/ready pair. A grant is the offer. The strobe is the consumer's acceptance, and the offer cannot change or vanish before it (unless the block is inhibited). There is no other back-pressure.

Top module: `dma_prio_arbiter`

## Requirements
- R1: After reset, `grant` is 0, both fault flags are 0, and the rotating order starts with channel 0 highest.
- R2: With `prio_mode` = 0, an idle arbiter grants the requesting channel highest in the order 0, 1, 2, 3.
- R3: With `prio_mode` = 1, the order is 0, then 2, then 3, then 1.
- R4: With `prio_mode` = 2, the order is 2, then 0, then 1, then 3.
- R5: With `prio_mode` = 3, the search begins at the channel one above the last granted channel and wraps from 3 to 0. The last granted channel therefore ranks lowest.
- R6: `grant` is always one-hot or zero, in bit order channel 0 = bit 0. A new grant goes only to a channel whose request was high at the arbitration edge, and it appears in the cycle after that edge.
- R7: A held grant does not change while `unit_done` is low, whatever the requests do. When `unit_done` is high with a grant held, `grant` is 0 in the next cycle, and arbitration resumes the cycle after that. When `unit_done` is high with no grant held, it has no effect.
- R8: While `master_en` is low, no grant is issued, and a held grant is 0 in the next cycle.
- R9: A pulse on `addr_err_set` or `nmi_set` sets the matching flag in the next cycle. While either flag is 1, `grant` is 0 from the following cycle on.
- R10: The flags stay set until `err_clr` is high, which clears both in the next cycle. A set pulse in the same cycle as a clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ch_req | input | 4 | Request line per channel |
| prio_mode | input | 2 | Priority order select (0..3) |
| master_en | input | 1 | Global permission for grants |
| unit_done | input | 1 | Completion strobe for the granted transfer unit |
| addr_err_set | input | 1 | Pulse that raises the address-fault flag |
| nmi_set | input | 1 | Pulse that raises the NMI flag |
| err_clr | input | 1 | Clears both fault flags |
| grant | output | 4 | One-hot grant, zero when idle |
| addr_err | output | 1 | Sticky address-fault flag |
| nmi_flag | output | 1 | Sticky NMI flag |

## Verification
The properties assume that every input is synchronous to `clk` and stable around the rising edge. They also assume that `prio_mode` is valid at the edge where arbitration happens. No assumption is made about `unit_done` arriving only while a grant is held, because a stray strobe is defined to be harmless. The stimulus changes inputs only on the falling edge. Its random phase drives strobes, fault pulses and mode changes freely, including strobes with no grant held. A cycle-by-cycle behavioural model then checks every result.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  localparam int NCH   = 4;
  localparam int IDX_W = $clog2(NCH);
  localparam int NFLAG = 2;

  typedef logic [NCH-1:0]   ch_vec_t;
  typedef logic [IDX_W-1:0] ch_idx_t;

  typedef enum logic [1:0] {
    PM_ASCEND    = 2'd0,
    PM_ZERO_HEAD = 2'd1,
    PM_TWO_HEAD  = 2'd2,
    PM_ROTATE    = 2'd3
  } prio_mode_e;

  // channel placed at a given rank for the fixed orders
  function automatic ch_idx_t fixed_rank(input prio_mode_e mode, input int rank);
    ch_idx_t res;
    res = ch_idx_t'(rank);
    case (mode)
      PM_ZERO_HEAD: begin
        case (rank)
          0: res = 2'd0;
          1: res = 2'd2;
          2: res = 2'd3;
          default: res = 2'd1;
        endcase
      end
      PM_TWO_HEAD: begin
        case (rank)
          0: res = 2'd2;
          1: res = 2'd0;
          2: res = 2'd1;
          default: res = 2'd3;
        endcase
      end
      default: res = ch_idx_t'(rank);
    endcase
    return res;
  endfunction
endpackage

// File: rtl/dma_arb_rank_map.sv
module dma_arb_rank_map
  import dma_arb_pkg::*;
(
  input  prio_mode_e mode,
  input  ch_idx_t    last_idx,
  output ch_idx_t    rank_ch [NCH]
);
  generate
    for (genvar r = 0; r < NCH; r++) begin : g_rank
      always_comb begin
        if (mode == PM_ROTATE)
          rank_ch[r] = ch_idx_t'(last_idx + ch_idx_t'(r + 1));
        else
          rank_ch[r] = fixed_rank(mode, r);
      end
    end
  endgenerate
endmodule

// File: rtl/dma_arb_pick.sv
module dma_arb_pick
  import dma_arb_pkg::*;
(
  input  ch_vec_t req,
  input  ch_idx_t rank_ch [NCH],
  output logic    any,
  output ch_idx_t win_idx
);
  always_comb begin
    any     = 1'b0;
    win_idx = '0;
    // scan from lowest rank upward so the highest rank overrides
    for (int r = NCH - 1; r >= 0; r--) begin
      if (req[rank_ch[r]]) begin
        any     = 1'b1;
        win_idx = rank_ch[r];
      end
    end
  end
endmodule

// File: rtl/dma_arb_sticky.sv
module dma_arb_sticky #(
  parameter int NFLAG = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] set_pulse,
  input  logic             clr,
  output logic [NFLAG-1:0] flag
);
  generate
    for (genvar f = 0; f < NFLAG; f++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            flag[f] <= 1'b0;
        else if (set_pulse[f]) flag[f] <= 1'b1;
        else if (clr)          flag[f] <= 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/dma_prio_arbiter.sv
module dma_prio_arbiter
  import dma_arb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] ch_req,
  input  logic [1:0] prio_mode,
  input  logic       master_en,
  input  logic       unit_done,
  input  logic       addr_err_set,
  input  logic       nmi_set,
  input  logic       err_clr,
  output logic [3:0] grant,
  output logic       addr_err,
  output logic       nmi_flag
);
  ch_vec_t         grant_q;
  ch_idx_t         last_q;
  ch_idx_t         rank_ch [NCH];
  ch_idx_t         win_idx;
  logic            win_any;
  logic            inhibit;
  logic [NFLAG-1:0] flags;

  dma_arb_sticky #(.NFLAG(NFLAG)) u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_pulse ({nmi_set, addr_err_set}),
    .clr       (err_clr),
    .flag      (flags)
  );

  dma_arb_rank_map u_map (
    .mode     (prio_mode_e'(prio_mode)),
    .last_idx (last_q),
    .rank_ch  (rank_ch)
  );

  dma_arb_pick u_pick (
    .req     (ch_req),
    .rank_ch (rank_ch),
    .any     (win_any),
    .win_idx (win_idx)
  );

  assign inhibit = !master_en || (|flags);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q <= '0;
      last_q  <= ch_idx_t'(NCH - 1);   // channel 0 ranks first
    end else if (inhibit) begin
      grant_q <= '0;
    end else if (grant_q != '0) begin
      if (unit_done) grant_q <= '0;
    end else if (win_any) begin
      grant_q <= ch_vec_t'(1) << win_idx;
      last_q  <= win_idx;
    end
  end

  assign grant    = grant_q;
  assign addr_err = flags[0];
  assign nmi_flag = flags[1];
endmodule

// File: rtl/dma_prio_arbiter_chk.sv
module dma_prio_arbiter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] ch_req,
  input logic [1:0] prio_mode,
  input logic       master_en,
  input logic       unit_done,
  input logic       addr_err_set,
  input logic       nmi_set,
  input logic       err_clr,
  input logic [3:0] grant,
  input logic       addr_err,
  input logic       nmi_flag
);
  logic idle_ok;
  assign idle_ok = (grant == 4'b0) && master_en && !addr_err && !nmi_flag;

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R6
  AST_GRANT_TO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (grant == 4'b0) |=> (grant == 4'b0) || ((grant & $past(ch_req)) != 4'b0)); // R6
  AST_MODE0_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_ok && prio_mode == 2'd0 && ch_req[0]) |=> grant == 4'b0001); // R2
  AST_MODE1_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_ok && prio_mode == 2'd1 && !ch_req[0] && ch_req[2]) |=> grant == 4'b0100); // R3
  AST_MODE2_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_ok && prio_mode == 2'd2 && ch_req[2]) |=> grant == 4'b0100); // R4
  AST_GRANT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != 4'b0 && !unit_done && master_en && !addr_err && !nmi_flag) |=> $stable(grant)); // R7
  AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != 4'b0 && unit_done) |=> grant == 4'b0); // R7
  AST_MASTER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !master_en |=> grant == 4'b0); // R8
  AST_FAULT_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_err || nmi_flag) |=> grant == 4'b0); // R9
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    addr_err_set |=> addr_err); // R9
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_flag && !err_clr) |=> nmi_flag); // R10
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr && !addr_err_set) |=> !addr_err); // R10
endmodule

bind dma_prio_arbiter dma_prio_arbiter_chk u_chk (.*);

// File: tb/dma_prio_arbiter_tb.sv
`timescale 1ns/1ps
module dma_prio_arbiter_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] ch_req = '0;
  logic [1:0] prio_mode = '0;
  logic       master_en = 1'b0;
  logic       unit_done = 1'b0;
  logic       addr_err_set = 1'b0;
  logic       nmi_set = 1'b0;
  logic       err_clr = 1'b0;
  logic [3:0] grant;
  logic       addr_err;
  logic       nmi_flag;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;   // 50 MHz

  dma_prio_arbiter u_dut (
    .clk(clk), .rst_n(rst_n), .ch_req(ch_req), .prio_mode(prio_mode),
    .master_en(master_en), .unit_done(unit_done), .addr_err_set(addr_err_set),
    .nmi_set(nmi_set), .err_clr(err_clr), .grant(grant),
    .addr_err(addr_err), .nmi_flag(nmi_flag)
  );

  // behavioural reference model
  int m_grant;      // granted channel, -1 when idle
  int m_last;
  bit m_ae, m_nmi;

  function automatic int pick(input int mode, input int last, input logic [3:0] req);
    int ord[4];
    case (mode)
      0: ord = '{0, 1, 2, 3};
      1: ord = '{0, 2, 3, 1};
      2: ord = '{2, 0, 1, 3};
      default: for (int k = 0; k < 4; k++) ord[k] = (last + 1 + k) % 4;
    endcase
    for (int k = 0; k < 4; k++) if (req[ord[k]]) return ord[k];
    return -1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_grant <= -1; m_last <= 3; m_ae <= 0; m_nmi <= 0;
    end else begin
      if (!master_en || m_ae || m_nmi) m_grant <= -1;
      else if (m_grant >= 0) begin
        if (unit_done) m_grant <= -1;
      end else begin
        int w;
        w = pick(prio_mode, m_last, ch_req);
        if (w >= 0) begin m_grant <= w; m_last <= w; end
      end
      m_ae  <= addr_err_set ? 1'b1 : (err_clr ? 1'b0 : m_ae);
      m_nmi <= nmi_set      ? 1'b1 : (err_clr ? 1'b0 : m_nmi);
    end
  end

  function automatic logic [3:0] onehot(input int ch);
    return (ch < 0) ? 4'b0 : (4'b1 << ch);
  endfunction

  task automatic chk(input string req, input string what, input logic [3:0] got, input logic [3:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %b expected %b", req, what, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    cycles++;
    chk(cur_req, "grant vs model", grant, onehot(m_grant));
    chk(cur_req, "flags vs model", {2'b0, nmi_flag, addr_err}, {2'b0, m_nmi, m_ae});
  endtask

  task automatic quiet();
    ch_req = '0; unit_done = 0; addr_err_set = 0; nmi_set = 0; err_clr = 0;
  endtask

  // grant from idle with given mode and requests, then release it
  task automatic arb(input string req, input int mode, input logic [3:0] rq, input logic [3:0] exp);
    cur_req = req; prio_mode = mode[1:0]; ch_req = rq;
    tick();
    chk(req, "grant pick", grant, exp);
    ch_req = '0; unit_done = 1;
    tick();
    unit_done = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "reset grant", grant, 4'b0);
    chk("R1", "reset flags", {2'b0, nmi_flag, addr_err}, 4'b0);
    rst_n = 1;
    master_en = 1;
    tick();

    arb("R2", 0, 4'b1111, 4'b0001);
    arb("R2", 0, 4'b1100, 4'b0100);
    arb("R3", 1, 4'b1010, 4'b1000);
    arb("R3", 1, 4'b1110, 4'b0100);
    arb("R3", 1, 4'b0011, 4'b0001);
    arb("R4", 2, 4'b1111, 4'b0100);
    arb("R4", 2, 4'b1010, 4'b0010);
    arb("R4", 2, 4'b1001, 4'b0001);

    // rotation from reset ordering: fresh reset, all request
    rst_n = 0; @(negedge clk); rst_n = 1;
    arb("R1", 3, 4'b1111, 4'b0001);
    arb("R5", 3, 4'b1111, 4'b0010);
    arb("R5", 3, 4'b1111, 4'b0100);
    arb("R5", 3, 4'b1111, 4'b1000);
    arb("R5", 3, 4'b1111, 4'b0001);
    arb("R5", 3, 4'b0101, 4'b0100);
    arb("R5", 3, 4'b0101, 4'b0001);

    // hold until done; requests change meanwhile
    cur_req = "R7"; prio_mode = 0; ch_req = 4'b1000; tick();
    ch_req = 4'b0001; tick(); tick();
    chk("R7", "held grant", grant, 4'b1000);
    unit_done = 1; tick();
    chk("R7", "release", grant, 4'b0000);
    unit_done = 0; tick();
    chk("R7", "re-arbitrate", grant, 4'b0001);
    unit_done = 1; ch_req = 0; tick(); tick();
    chk("R7", "stray done ignored", grant, 4'b0000);
    unit_done = 0; ch_req = 4'b0010; tick();
    chk("R7", "grant after stray done", grant, 4'b0010);

    // master enable
    cur_req = "R8"; master_en = 0; tick();
    chk("R8", "drop on disable", grant, 4'b0);
    ch_req = 4'b1111; tick();
    chk("R8", "no grant disabled", grant, 4'b0);
    master_en = 1; tick();
    chk("R8", "grant re-enabled", grant, 4'b0001);

    // fault flags
    cur_req = "R9"; addr_err_set = 1; tick();
    chk("R9", "addr flag set", {3'b0, addr_err}, 4'b0001);
    addr_err_set = 0; tick();
    chk("R9", "drop on fault", grant, 4'b0);
    unit_done = 1; tick(); unit_done = 0; tick();
    chk("R9", "no grant in fault", grant, 4'b0);
    cur_req = "R10"; nmi_set = 1; err_clr = 1; tick();
    chk("R10", "set beats clear", {2'b0, nmi_flag, addr_err}, 4'b0010);
    nmi_set = 0; tick();
    chk("R10", "cleared", {2'b0, nmi_flag, addr_err}, 4'b0000);
    err_clr = 0; tick();
    chk("R10", "grant after clear", grant, 4'b0001);
    quiet(); unit_done = 1; tick(); unit_done = 0;

    // random phase
    cur_req = "R6";
    for (int i = 0; i < 3000; i++) begin
      ch_req       = 4'($urandom);
      prio_mode    = 2'($urandom);
      unit_done    = ($urandom % 3) == 0;
      master_en    = ($urandom % 20) != 0;
      addr_err_set = ($urandom % 60) == 0;
      nmi_set      = ($urandom % 80) == 0;
      err_clr      = ($urandom % 12) == 0;
      tick();
      chk("R6", "one-hot", {3'b0, $countones(grant) > 1}, 4'b0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #4000000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule